// File: doc/BRIEF.md
# Leapfrog Segmented DAC Switch Decoder

This block turns a DAC input word into the switch controls of a segmented converter. The coarse field of the word picks one of sixteen segments of a resistor string. Two coarse selectors tap the two nodes that bound that segment, and a fine code drives the interpolating sub-DAC between them.

The selectors leapfrog. Even string nodes belong to selector A and odd nodes belong to selector B. When the segment number steps up by one, only one selector moves, and the other stays on the node the two segments share. On segments where selector A sits on the upper node, the sub-DAC inputs are swapped. The block complements the fine code on those segments so that the output stays monotonic.

A reduced-resolution mode takes a 14-bit word with a 10-bit fine code. All outputs are registered and change only on a load strobe, so the one-hot tap vectors never glitch.

Top module: `leapfrog_dac_decoder`

## Requirements
- R1: After reset, tap_a_o is 9'b000000001 (node 0), tap_b_o is 8'b00000001 (node 1) and fine_o is zero.
- R2: In full mode (reduced_i=0), the segment k is data_i[15:12] and the raw fine code is data_i[11:0].
- R3: Bit i of tap_a_o selects string node 2i, and bit i of tap_b_o selects node 2i+1. Each vector is exactly one-hot.
- R4: For segment k, the two selected nodes are k and k+1. tap_a_o has bit (k+1)>>1 set and tap_b_o has bit k>>1 set.
- R5: fine_o equals the raw fine code when k is even. It equals the bitwise complement of the raw fine code, over the active fine width, when k is odd.
- R6: In reduced mode (reduced_i=1), k is data_i[13:10] and the raw fine code is data_i[9:0]. fine_o[11:10] is 0, only bits [9:0] are complemented, and data_i[15:14] has no effect.
- R7: Outputs take new values only in the cycle after load_i is sampled high. At all other times they hold.
- R8: Loading segment k and then segment k+1 changes exactly one of tap_a_o and tap_b_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe; captures the decoded word |
| reduced_i | input | 1 | 1 selects the 14-bit word with a 10-bit fine code |
| data_i | input | 16 | DAC input word |
| tap_a_o | output | 9 | One-hot select of the even string nodes |
| tap_b_o | output | 8 | One-hot select of the odd string nodes |
| fine_o | output | 12 | Fine code for the sub-DAC, folded on odd segments |

## Verification
The bench builds the block with its default parameters: a 4-bit segment field, a 12-bit fine code and 2 bits dropped in reduced mode. These give 17 nodes across 9 even and 8 odd switches, so every segment can be swept in both modes. The sweep reaches the string ends (segments 0 and 15) and checks each single-step move for the leapfrog property. Random words and directed all-zero and all-one fine codes show the complement boundary and the masking of the two unused bits in reduced mode.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_RED  = 1'b1
  } mode_e;
endpackage

// File: rtl/ldd_word_split.sv
module ldd_word_split #(
  parameter int SEG_W    = 4,
  parameter int FINE_W   = 12,
  parameter int RED_DROP = 2
) (
  input  logic [SEG_W+FINE_W-1:0] word_i,
  input  ldd_pkg::mode_e          mode_i,
  output logic [SEG_W-1:0]        seg_o,
  output logic [FINE_W-1:0]       fine_o
);
  localparam int WORD_W  = SEG_W + FINE_W;
  localparam int RFINE_W = FINE_W - RED_DROP;

  always_comb begin
    if (mode_i == ldd_pkg::MODE_RED) begin
      seg_o  = word_i[WORD_W-RED_DROP-1 -: SEG_W];
      fine_o = {{RED_DROP{1'b0}}, word_i[RFINE_W-1:0]};
    end else begin
      seg_o  = word_i[WORD_W-1 -: SEG_W];
      fine_o = word_i[FINE_W-1:0];
    end
  end
endmodule

// File: rtl/ldd_tap_decode.sv
module ldd_tap_decode #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0]          seg_i,
  output logic [2**(SEG_W-1):0]     tap_a_o,
  output logic [2**(SEG_W-1)-1:0]   tap_b_o
);
  localparam int A_W = 2**(SEG_W-1) + 1;
  localparam int B_W = 2**(SEG_W-1);

  logic [SEG_W:0]   seg_p1;
  logic [SEG_W-1:0] idx_a;
  logic [SEG_W-1:0] idx_b;

  // even nodes go to A: upper node on odd k, lower on even k
  assign seg_p1 = {1'b0, seg_i} + 1'b1;
  assign idx_a  = seg_p1[SEG_W:1];
  assign idx_b  = {1'b0, seg_i[SEG_W-1:1]};

  for (genvar i = 0; i < A_W; i++) begin : g_a
    assign tap_a_o[i] = (idx_a == SEG_W'(i));
  end
  for (genvar j = 0; j < B_W; j++) begin : g_b
    assign tap_b_o[j] = (idx_b == SEG_W'(j));
  end
endmodule

// File: rtl/ldd_fine_fold.sv
module ldd_fine_fold #(
  parameter int FINE_W   = 12,
  parameter int RED_DROP = 2
) (
  input  logic [FINE_W-1:0] fine_i,
  input  logic              seg_odd_i,
  input  ldd_pkg::mode_e    mode_i,
  output logic [FINE_W-1:0] fine_o
);
  localparam int RFINE_W = FINE_W - RED_DROP;

  logic [FINE_W-1:0] mask;

  assign mask   = {{RED_DROP{mode_i == ldd_pkg::MODE_FULL}}, {RFINE_W{1'b1}}};
  assign fine_o = seg_odd_i ? (fine_i ^ mask) : fine_i;
endmodule

// File: rtl/leapfrog_dac_decoder.sv
module leapfrog_dac_decoder #(
  parameter int SEG_W    = 4,
  parameter int FINE_W   = 12,
  parameter int RED_DROP = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        reduced_i,
  input  logic [SEG_W+FINE_W-1:0]     data_i,
  output logic [2**(SEG_W-1):0]       tap_a_o,
  output logic [2**(SEG_W-1)-1:0]     tap_b_o,
  output logic [FINE_W-1:0]           fine_o
);
  import ldd_pkg::*;

  localparam int A_W = 2**(SEG_W-1) + 1;
  localparam int B_W = 2**(SEG_W-1);

  mode_e             mode;
  logic [SEG_W-1:0]  seg;
  logic [FINE_W-1:0] fine_raw;
  logic [FINE_W-1:0] fine_fold;
  logic [A_W-1:0]    tap_a_d;
  logic [B_W-1:0]    tap_b_d;

  assign mode = reduced_i ? MODE_RED : MODE_FULL;

  ldd_word_split #(.SEG_W(SEG_W), .FINE_W(FINE_W), .RED_DROP(RED_DROP)) u_split (
    .word_i (data_i),
    .mode_i (mode),
    .seg_o  (seg),
    .fine_o (fine_raw)
  );

  ldd_tap_decode #(.SEG_W(SEG_W)) u_taps (
    .seg_i   (seg),
    .tap_a_o (tap_a_d),
    .tap_b_o (tap_b_d)
  );

  ldd_fine_fold #(.FINE_W(FINE_W), .RED_DROP(RED_DROP)) u_fold (
    .fine_i    (fine_raw),
    .seg_odd_i (seg[0]),
    .mode_i    (mode),
    .fine_o    (fine_fold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_a_o <= A_W'(1);
      tap_b_o <= B_W'(1);
      fine_o  <= '0;
    end else if (load_i) begin
      tap_a_o <= tap_a_d;
      tap_b_o <= tap_b_d;
      fine_o  <= fine_fold;
    end
  end

  a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(tap_a_o) && $onehot(tap_b_o));

  // R4: selected nodes are adjacent
  a_r4_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_a_o == {tap_b_o, 1'b0}) || (tap_a_o == {1'b0, tap_b_o}));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tap_a_o) && $stable(tap_b_o) && $stable(fine_o));

  a_r6_red_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && reduced_i) |=> (fine_o[FINE_W-1 -: RED_DROP] == '0));
endmodule

// File: tb/leapfrog_dac_decoder_tb.sv
`timescale 1ns/1ps
module leapfrog_dac_decoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load = 0;
  logic        red = 0;
  logic [15:0] data = '0;
  logic [8:0]  tap_a;
  logic [7:0]  tap_b;
  logic [11:0] fine;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  leapfrog_dac_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .reduced_i(red),
    .data_i(data), .tap_a_o(tap_a), .tap_b_o(tap_b), .fine_o(fine)
  );

  function automatic logic [28:0] expect_out(input logic r, input logic [15:0] d);
    int k;
    logic [11:0] f;
    logic [8:0] a;
    logic [7:0] b;
    if (r) begin
      k = int'(d[13:10]);
      f = {2'b00, d[9:0]};
      if (k % 2 == 1) f = f ^ 12'h3FF;
    end else begin
      k = int'(d[15:12]);
      f = d[11:0];
      if (k % 2 == 1) f = ~f;
    end
    a = '0; b = '0;
    a[(k + 1) / 2] = 1'b1;
    b[k / 2] = 1'b1;
    return {a, b, f};
  endfunction

  task automatic check(input string tag, input logic [28:0] exp_v);
    total++;
    if ({tap_a, tap_b, fine} !== exp_v) begin
      bad++;
      $display("FAIL %s: got a=%b b=%b f=%h exp a=%b b=%b f=%h", tag,
               tap_a, tap_b, fine, exp_v[28:20], exp_v[19:12], exp_v[11:0]);
    end
  endtask

  task automatic do_load(input logic r, input logic [15:0] d);
    @(negedge clk);
    load = 1; red = r; data = d;
    @(negedge clk);
    load = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [28:0] prev;
    logic [8:0]  pa;
    logic [7:0]  pb;
    logic [15:0] d;
    void'($urandom(32'h1D2C3));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {9'b1, 8'b1, 12'h000});
    rst_n = 1;
    @(negedge clk);
    check("R1 reset held", {9'b1, 8'b1, 12'h000});

    // R2 R4 R5 R8 full mode sweep, leapfrog step checks
    for (int k = 0; k < 16; k++) begin
      pa = tap_a; pb = tap_b;
      d = {4'(k), 12'h3A5};
      do_load(1'b0, d);
      check("R2/R4/R5 full sweep", expect_out(1'b0, d));
      if (k > 0) begin
        total++;
        if (((tap_a != pa) ? 1 : 0) + ((tap_b != pb) ? 1 : 0) != 1) begin
          bad++;
          $display("FAIL R8 step to seg %0d: a %b->%b b %b->%b exp one change",
                   k, pa, tap_a, pb, tap_b);
        end
      end
    end

    // R5 complement boundaries
    do_load(1'b0, 16'h1000); check("R5 odd zero fine", expect_out(1'b0, 16'h1000));
    do_load(1'b0, 16'hFFFF); check("R5 odd ones fine", expect_out(1'b0, 16'hFFFF));
    do_load(1'b0, 16'h0FFF); check("R5 even ones fine", expect_out(1'b0, 16'h0FFF));
    do_load(1'b0, 16'h0000); check("R4 seg0 end", expect_out(1'b0, 16'h0000));

    // R6 reduced mode sweep with leapfrog
    for (int k = 0; k < 16; k++) begin
      pa = tap_a; pb = tap_b;
      d = {2'b10, 4'(k), 10'h15A};
      do_load(1'b1, d);
      check("R6 reduced sweep", expect_out(1'b1, d));
      if (k > 0) begin
        total++;
        if (((tap_a != pa) ? 1 : 0) + ((tap_b != pb) ? 1 : 0) != 1) begin
          bad++;
          $display("FAIL R8 reduced step to seg %0d: a %b->%b b %b->%b exp one change",
                   k, pa, tap_a, pb, tap_b);
        end
      end
    end
    // R6 upper bits ignored
    do_load(1'b1, 16'h07FF); check("R6 top bits 00", expect_out(1'b1, 16'h07FF));
    do_load(1'b1, 16'hC7FF); check("R6 top bits 11", expect_out(1'b1, 16'h07FF));
    do_load(1'b1, 16'h3C00); check("R6 odd zero fine", expect_out(1'b1, 16'h3C00));

    // R7 hold without load
    prev = expect_out(1'b1, 16'h3C00);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      data = 16'($urandom); red = 1'($urandom);
      @(negedge clk);
      check("R7 hold", prev);
    end

    // R2 R5 R6 random
    for (int n = 0; n < 400; n++) begin
      logic r;
      r = 1'($urandom);
      d = 16'($urandom);
      do_load(r, d);
      check(r ? "R6 random" : "R2/R5 random", expect_out(r, d));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule